// File: doc/BRIEF.md
# Sub-Pixel Frame Buffer Address Generator

This block turns a pair of signed Q15.16 fixed-point coordinates (row and column) into the byte address of a 32-bit pixel in a linear frame buffer. Line, curve and edge-drawing code can then keep its fractional sub-pixel positions in ordinary 32-bit registers and address memory with them directly. The block does not first convert them to integers. The integer pixel index of each coordinate comes from its upper half with the sign bit dropped. The column index is scaled by the 4-byte pixel size. The row index is scaled by the row stride (in pixels) and by the pixel size. Both are added to a 32-bit base address.

The row stride is an unsigned 15-bit quantity. Each request picks whether it comes from a 15-bit immediate field or from the low bits of a register operand. The unit has two pipeline stages: the first forms the stride product and the second forms the final sum. It accepts one request per clock, marked by a valid strobe, and delivers each result with a matching valid strobe two cycles later. The 16 fractional bits of both coordinates travel alongside the address unchanged, for use in coverage or antialiasing weights.

Top module: `pixaddr_gen`

## Requirements
- R1: While reset is held and after it is released, before any request is accepted, `out_valid` is 0 and `out_addr`, `out_row_frac` and `out_col_frac` are all zero.
- R2: A request presented with `in_valid` = 1 at a rising clock edge produces `out_valid` = 1 exactly two rising edges later. A cycle with `in_valid` = 0 produces `out_valid` = 0 two edges later.
- R3: The pixel index of a coordinate is its bits 30 down to 16, meaning (coord >> 16) & 0x7FFF. Bit 31 is ignored, so a negative coordinate aliases onto a large positive index. For example, row 0xFFFF_0000 (-1.0) addresses row 0x7FFF.
- R4: `out_addr` = base + 4 × column index + 4 × stride × row index.
- R5: With `in_stride_sel` = 1 the stride is `in_stride_imm`. With `in_stride_sel` = 0 the stride is bits 14 down to 0 of `in_stride_reg`, and its upper bits have no effect on the address.
- R6: `out_row_frac` and `out_col_frac` equal bits 15 down to 0 of the request's row and column, delivered in the same cycle as its address.
- R7: The final sum wraps modulo 2^32; a carry out of bit 31 is discarded.
- R8: The largest stride (0x7FFF) combined with the largest row and column indices (0x7FFF) gives the exact address with no truncation. With base 0 that address is 0xFFFE_0000.
- R9: In cycles with no new result (`out_valid` = 0), `out_addr` and both fraction outputs keep the values of the most recent result. Inputs presented with `in_valid` = 0 do not affect them.
- R10: Requests on consecutive cycles are each processed independently and emerge in order on consecutive cycles, with no stall and no mixing of operands between neighbours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| in_valid | input | 1 | Request strobe; one request per cycle |
| in_base | input | 32 | Frame buffer base byte address |
| in_stride_sel | input | 1 | Stride source: 1 = immediate, 0 = register |
| in_stride_imm | input | 15 | Immediate row stride in pixels |
| in_stride_reg | input | 32 | Register operand; bits 14:0 give the row stride |
| in_row | input | 32 | Row coordinate, Q15.16 |
| in_col | input | 32 | Column coordinate, Q15.16 |
| out_valid | output | 1 | Result strobe, two cycles after the request |
| out_addr | output | 32 | Pixel byte address |
| out_row_frac | output | 16 | Fraction bits of the row coordinate |
| out_col_frac | output | 16 | Fraction bits of the column coordinate |

## Verification
The hardest behaviour to reach is operand mixing between neighbouring requests in a full-rate stream. A fault there only shows when several back-to-back requests differ in every field, including the stride source and the sign bits. The stimulus therefore runs an unbroken burst in which each field is a different arithmetic function of the step number, the stride source alternates every cycle, and every other row has bit 31 set. The corner values come in dedicated requests: a negative row, the largest stride with the largest indices, and a base near the top of the address space. Idle cycles with junk operands follow a result, to show that the held outputs stay untouched.

// File: rtl/pixaddr_pkg.sv
package pixaddr_pkg;

  // Default geometry of the coordinate and address paths.
  localparam int ADDR_W_DEF    = 32;
  localparam int COORD_W_DEF   = 32;
  localparam int FRAC_W_DEF    = 16;
  localparam int IDX_W_DEF     = 15;
  localparam int STRIDE_W_DEF  = 15;
  localparam int SREG_W_DEF    = 32;
  localparam int PIX_SHIFT_DEF = 2;   // log2 of the bytes per pixel
  localparam int RST_SYNC_DEF  = 2;

  // Where the row stride of a request comes from.
  typedef enum logic {
    STRIDE_FROM_REG = 1'b0,
    STRIDE_FROM_IMM = 1'b1
  } stride_src_e;

endpackage

// File: rtl/pixaddr_rst_sync.sv
// Reset conditioner: asserts at once and releases after STAGES clock edges.
module pixaddr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/pixaddr_coord_split.sv
// Splits a signed fixed-point coordinate into a masked pixel index and its
// fraction. Bits above the index (the sign bit) are dropped.
module pixaddr_coord_split #(
  parameter int COORD_W = 32,
  parameter int FRAC_W  = 16,
  parameter int IDX_W   = 15
) (
  input  logic [COORD_W-1:0] coord_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic [FRAC_W-1:0]  frac_o
);

  localparam int TOP_LSB = FRAC_W + IDX_W;

  assign idx_o  = coord_i[TOP_LSB-1:FRAC_W];
  assign frac_o = coord_i[FRAC_W-1:0];

  generate
    if (TOP_LSB < COORD_W) begin : g_drop_hi
      logic unused_hi;
      assign unused_hi = ^coord_i[COORD_W-1:TOP_LSB];
    end
  endgenerate

endmodule

// File: rtl/pixaddr_mul_stage.sv
// First stage: row index times stride; the other operands are carried along.
module pixaddr_mul_stage #(
  parameter int ADDR_W   = 32,
  parameter int FRAC_W   = 16,
  parameter int IDX_W    = 15,
  parameter int STRIDE_W = 15
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        valid_i,
  input  logic [IDX_W-1:0]            row_idx_i,
  input  logic [IDX_W-1:0]            col_idx_i,
  input  logic [STRIDE_W-1:0]         stride_i,
  input  logic [ADDR_W-1:0]           base_i,
  input  logic [FRAC_W-1:0]           row_frac_i,
  input  logic [FRAC_W-1:0]           col_frac_i,
  output logic                        valid_o,
  output logic [IDX_W+STRIDE_W-1:0]   prod_o,
  output logic [IDX_W-1:0]            col_idx_o,
  output logic [ADDR_W-1:0]           base_o,
  output logic [FRAC_W-1:0]           row_frac_o,
  output logic [FRAC_W-1:0]           col_frac_o
);

  localparam int PROD_W = IDX_W + STRIDE_W;

  logic [PROD_W-1:0] prod_d;
  logic              load_en;

  always_comb begin
    prod_d  = PROD_W'(row_idx_i) * PROD_W'(stride_i);
    load_en = valid_i;
  end

  // Valid strobe: advances every cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
    end
  end

  // Operand registers: loaded only for a live request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_o     <= '0;
      col_idx_o  <= '0;
      base_o     <= '0;
      row_frac_o <= '0;
      col_frac_o <= '0;
    end else if (load_en) begin
      prod_o     <= prod_d;
      col_idx_o  <= col_idx_i;
      base_o     <= base_i;
      row_frac_o <= row_frac_i;
      col_frac_o <= col_frac_i;
    end
  end

endmodule

// File: rtl/pixaddr_sum_stage.sv
// Second stage: scales both terms by the pixel size and adds the base.
module pixaddr_sum_stage #(
  parameter int ADDR_W    = 32,
  parameter int FRAC_W    = 16,
  parameter int IDX_W     = 15,
  parameter int STRIDE_W  = 15,
  parameter int PIX_SHIFT = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      valid_i,
  input  logic [IDX_W+STRIDE_W-1:0] prod_i,
  input  logic [IDX_W-1:0]          col_idx_i,
  input  logic [ADDR_W-1:0]         base_i,
  input  logic [FRAC_W-1:0]         row_frac_i,
  input  logic [FRAC_W-1:0]         col_frac_i,
  output logic                      valid_o,
  output logic [ADDR_W-1:0]         addr_o,
  output logic [FRAC_W-1:0]         row_frac_o,
  output logic [FRAC_W-1:0]         col_frac_o
);

  localparam int PROD_W = IDX_W + STRIDE_W;
  localparam int ROW_BYTES_W = PROD_W + PIX_SHIFT;
  localparam int COL_BYTES_W = IDX_W + PIX_SHIFT;

  logic [ROW_BYTES_W-1:0] row_bytes;
  logic [COL_BYTES_W-1:0] col_bytes;
  logic [ADDR_W-1:0]      addr_d;
  logic                   load_en;

  always_comb begin
    row_bytes = {prod_i, {PIX_SHIFT{1'b0}}};
    col_bytes = {col_idx_i, {PIX_SHIFT{1'b0}}};
    addr_d    = base_i + ADDR_W'(col_bytes) + ADDR_W'(row_bytes);
    load_en   = valid_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o     <= '0;
      row_frac_o <= '0;
      col_frac_o <= '0;
    end else if (load_en) begin
      addr_o     <= addr_d;
      row_frac_o <= row_frac_i;
      col_frac_o <= col_frac_i;
    end
  end

endmodule

// File: rtl/pixaddr_gen.sv
// Sub-pixel coordinate to frame buffer byte address, two-stage pipeline.
module pixaddr_gen
  import pixaddr_pkg::*;
#(
  parameter int ADDR_W     = ADDR_W_DEF,
  parameter int COORD_W    = COORD_W_DEF,
  parameter int FRAC_W     = FRAC_W_DEF,
  parameter int IDX_W      = IDX_W_DEF,
  parameter int STRIDE_W   = STRIDE_W_DEF,
  parameter int SREG_W     = SREG_W_DEF,
  parameter int PIX_SHIFT  = PIX_SHIFT_DEF,
  parameter int RST_STAGES = RST_SYNC_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [ADDR_W-1:0]   in_base,
  input  logic                in_stride_sel,
  input  logic [STRIDE_W-1:0] in_stride_imm,
  input  logic [SREG_W-1:0]   in_stride_reg,
  input  logic [COORD_W-1:0]  in_row,
  input  logic [COORD_W-1:0]  in_col,
  output logic                out_valid,
  output logic [ADDR_W-1:0]   out_addr,
  output logic [FRAC_W-1:0]   out_row_frac,
  output logic [FRAC_W-1:0]   out_col_frac
);

  localparam int NUM_AXES = 2;   // 0 = row, 1 = column
  localparam int PROD_W   = IDX_W + STRIDE_W;

  logic rst_q_n;

  pixaddr_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  // Coordinate splitting, one slice per axis.
  logic [COORD_W-1:0] axis_coord [NUM_AXES];
  logic [IDX_W-1:0]   axis_idx   [NUM_AXES];
  logic [FRAC_W-1:0]  axis_frac  [NUM_AXES];

  assign axis_coord[0] = in_row;
  assign axis_coord[1] = in_col;

  generate
    for (genvar g = 0; g < NUM_AXES; g++) begin : g_axis
      pixaddr_coord_split #(
        .COORD_W (COORD_W),
        .FRAC_W  (FRAC_W),
        .IDX_W   (IDX_W)
      ) u_split (
        .coord_i (axis_coord[g]),
        .idx_o   (axis_idx[g]),
        .frac_o  (axis_frac[g])
      );
    end
  endgenerate

  // Stride source selection.
  stride_src_e         stride_src;
  logic [STRIDE_W-1:0] stride_eff;

  always_comb begin
    stride_src = stride_src_e'(in_stride_sel);
    unique case (stride_src)
      STRIDE_FROM_IMM: stride_eff = in_stride_imm;
      default:         stride_eff = in_stride_reg[STRIDE_W-1:0];
    endcase
  end

  generate
    if (SREG_W > STRIDE_W) begin : g_sreg_hi
      logic unused_sreg_hi;
      assign unused_sreg_hi = ^in_stride_reg[SREG_W-1:STRIDE_W];
    end
  endgenerate

  // Stage 1 outputs.
  logic              s1_valid;
  logic [PROD_W-1:0] s1_prod;
  logic [IDX_W-1:0]  s1_col_idx;
  logic [ADDR_W-1:0] s1_base;
  logic [FRAC_W-1:0] s1_row_frac;
  logic [FRAC_W-1:0] s1_col_frac;

  pixaddr_mul_stage #(
    .ADDR_W   (ADDR_W),
    .FRAC_W   (FRAC_W),
    .IDX_W    (IDX_W),
    .STRIDE_W (STRIDE_W)
  ) u_mul (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .valid_i    (in_valid),
    .row_idx_i  (axis_idx[0]),
    .col_idx_i  (axis_idx[1]),
    .stride_i   (stride_eff),
    .base_i     (in_base),
    .row_frac_i (axis_frac[0]),
    .col_frac_i (axis_frac[1]),
    .valid_o    (s1_valid),
    .prod_o     (s1_prod),
    .col_idx_o  (s1_col_idx),
    .base_o     (s1_base),
    .row_frac_o (s1_row_frac),
    .col_frac_o (s1_col_frac)
  );

  pixaddr_sum_stage #(
    .ADDR_W    (ADDR_W),
    .FRAC_W    (FRAC_W),
    .IDX_W     (IDX_W),
    .STRIDE_W  (STRIDE_W),
    .PIX_SHIFT (PIX_SHIFT)
  ) u_sum (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .valid_i    (s1_valid),
    .prod_i     (s1_prod),
    .col_idx_i  (s1_col_idx),
    .base_i     (s1_base),
    .row_frac_i (s1_row_frac),
    .col_frac_i (s1_col_frac),
    .valid_o    (out_valid),
    .addr_o     (out_addr),
    .row_frac_o (out_row_frac),
    .col_frac_o (out_col_frac)
  );

endmodule

// File: rtl/pixaddr_gen_chk.sv
// Port-level properties of the address generator.
module pixaddr_gen_chk #(
  parameter int ADDR_W    = 32,
  parameter int COORD_W   = 32,
  parameter int FRAC_W    = 16,
  parameter int IDX_W     = 15,
  parameter int STRIDE_W  = 15,
  parameter int SREG_W    = 32,
  parameter int PIX_SHIFT = 2
) (
  input logic                clk,
  input logic                rst_q_n,
  input logic                in_valid,
  input logic [ADDR_W-1:0]   in_base,
  input logic                in_stride_sel,
  input logic [STRIDE_W-1:0] in_stride_imm,
  input logic [SREG_W-1:0]   in_stride_reg,
  input logic [COORD_W-1:0]  in_row,
  input logic [COORD_W-1:0]  in_col,
  input logic                out_valid,
  input logic [ADDR_W-1:0]   out_addr,
  input logic [FRAC_W-1:0]   out_row_frac,
  input logic [FRAC_W-1:0]   out_col_frac
);

  function automatic logic [ADDR_W-1:0] model_addr(
    input logic [ADDR_W-1:0]   b,
    input logic                sel,
    input logic [STRIDE_W-1:0] imm,
    input logic [SREG_W-1:0]   sreg,
    input logic [COORD_W-1:0]  r,
    input logic [COORD_W-1:0]  c
  );
    logic [ADDR_W-1:0] s, ri, ci;
    s  = sel ? ADDR_W'(imm) : ADDR_W'(sreg & SREG_W'((64'd1 << STRIDE_W) - 1));
    ri = ADDR_W'((r >> FRAC_W) & COORD_W'((64'd1 << IDX_W) - 1));
    ci = ADDR_W'((c >> FRAC_W) & COORD_W'((64'd1 << IDX_W) - 1));
    return b + (ci << PIX_SHIFT) + ((s * ri) << PIX_SHIFT);
  endfunction

  // R2: every request yields a result strobe two edges later.
  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |-> ##2 out_valid);

  // R2: no result strobe without a request.
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |-> ##2 !out_valid);

  // R3, R4, R5, R7: address of each request.
  assert_addr_value_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |-> ##2 (out_addr == $past(model_addr(in_base, in_stride_sel, in_stride_imm,
                                                   in_stride_reg, in_row, in_col), 2)));

  // R6: fractions travel with their address.
  assert_frac_pass_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |-> ##2 ((out_row_frac == $past(in_row[FRAC_W-1:0], 2)) &&
                      (out_col_frac == $past(in_col[FRAC_W-1:0], 2))));

  // R9: outputs hold when no request fills the slot.
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |-> ##2 ($stable(out_addr) && $stable(out_row_frac) && $stable(out_col_frac)));

endmodule

bind pixaddr_gen pixaddr_gen_chk #(
  .ADDR_W    (ADDR_W),
  .COORD_W   (COORD_W),
  .FRAC_W    (FRAC_W),
  .IDX_W     (IDX_W),
  .STRIDE_W  (STRIDE_W),
  .SREG_W    (SREG_W),
  .PIX_SHIFT (PIX_SHIFT)
) u_chk (
  .clk           (clk),
  .rst_q_n       (rst_q_n),
  .in_valid      (in_valid),
  .in_base       (in_base),
  .in_stride_sel (in_stride_sel),
  .in_stride_imm (in_stride_imm),
  .in_stride_reg (in_stride_reg),
  .in_row        (in_row),
  .in_col        (in_col),
  .out_valid     (out_valid),
  .out_addr      (out_addr),
  .out_row_frac  (out_row_frac),
  .out_col_frac  (out_col_frac)
);

// File: tb/pixaddr_gen_bench.sv
module pixaddr_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_base;
  logic        in_stride_sel;
  logic [14:0] in_stride_imm;
  logic [31:0] in_stride_reg;
  logic [31:0] in_row;
  logic [31:0] in_col;
  logic        out_valid;
  logic [31:0] out_addr;
  logic [15:0] out_row_frac;
  logic [15:0] out_col_frac;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;   // 250 MHz

  pixaddr_gen u_pixaddr_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_base       (in_base),
    .in_stride_sel (in_stride_sel),
    .in_stride_imm (in_stride_imm),
    .in_stride_reg (in_stride_reg),
    .in_row        (in_row),
    .in_col        (in_col),
    .out_valid     (out_valid),
    .out_addr      (out_addr),
    .out_row_frac  (out_row_frac),
    .out_col_frac  (out_col_frac)
  );

  // Reference model: one queue entry per clock, popped two cycles later.
  typedef struct {
    bit          v;
    logic [31:0] a;
    logic [15:0] rf;
    logic [15:0] cf;
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [31:0] hold_a  = '0;
  logic [15:0] hold_rf = '0;
  logic [15:0] hold_cf = '0;

  function automatic logic [31:0] ref_addr(input logic [31:0] b, input bit sel,
                                           input logic [14:0] imm, input logic [31:0] sreg,
                                           input logic [31:0] r, input logic [31:0] c);
    longint unsigned ri, ci, s, sum;
    ri  = (longint'(r) >> 16) & 64'h7FFF;
    ci  = (longint'(c) >> 16) & 64'h7FFF;
    s   = sel ? longint'(imm) : (longint'(sreg) & 64'h7FFF);
    sum = longint'(b) + 4 * ci + 4 * s * ri;
    return sum[31:0];
  endfunction

  task automatic check_eq(input string tag, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_out();
    exp_t e;
    e = q.pop_front();
    check_eq(e.tag, "out_valid", {31'b0, out_valid}, {31'b0, e.v});
    check_eq(e.tag, "out_addr", out_addr, e.a);
    check_eq(e.tag, "out_row_frac", {16'b0, out_row_frac}, {16'b0, e.rf});
    check_eq(e.tag, "out_col_frac", {16'b0, out_col_frac}, {16'b0, e.cf});
  endtask

  task automatic push_expect(input bit v, input logic [31:0] a,
                             input logic [15:0] rf, input logic [15:0] cf, input string tag);
    exp_t e;
    if (v) begin
      hold_a  = a;
      hold_rf = rf;
      hold_cf = cf;
    end
    e.v = v; e.a = hold_a; e.rf = hold_rf; e.cf = hold_cf; e.tag = tag;
    q.push_back(e);
  endtask

  // One clock of stimulus: check the slot due now, then drive the next request.
  task automatic step(input bit v, input logic [31:0] base, input bit sel,
                      input logic [14:0] imm, input logic [31:0] sreg,
                      input logic [31:0] row, input logic [31:0] col, input string tag);
    @(negedge clk);
    compare_out();
    in_valid      = v;
    in_base       = base;
    in_stride_sel = sel;
    in_stride_imm = imm;
    in_stride_reg = sreg;
    in_row        = row;
    in_col        = col;
    push_expect(v, ref_addr(base, sel, imm, sreg, row, col), row[15:0], col[15:0], tag);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_base = '0; in_stride_sel = 1'b0;
    in_stride_imm = '0; in_stride_reg = '0; in_row = '0; in_col = '0;
    repeat (4) @(negedge clk);
    // R1: state under reset
    check_eq("R1", "reset out_valid", {31'b0, out_valid}, 32'h0);
    check_eq("R1", "reset out_addr", out_addr, 32'h0);
    check_eq("R1", "reset row frac", {16'b0, out_row_frac}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R1", "post-release out_addr", out_addr, 32'h0);
    check_eq("R1", "post-release col frac", {16'b0, out_col_frac}, 32'h0);
    push_expect(1'b0, '0, '0, '0, "R1");
    push_expect(1'b0, '0, '0, '0, "R1");

    // R4/R6: plain request, row 3.5, column 10.25, register stride 640
    step(1, 32'h1000_0000, 0, 15'd0, 32'd640, 32'h0003_8000, 32'h000A_4000, "R4");
    step(0, '0, 0, '0, '0, '0, '0, "R2");
    step(0, '0, 0, '0, '0, '0, '0, "R6");
    // R3: negative row -1.0 aliases to index 0x7FFF
    step(1, 32'h0000_0000, 1, 15'd1, 32'h0, 32'hFFFF_0000, 32'h0000_0001, "R3");
    // R3: bit 31 ignored on the column, with fraction bits set
    step(1, 32'h0200_0000, 1, 15'd100, 32'h0, 32'h0001_FFFF, 32'h8005_1234, "R3");
    // R5: register stride with junk upper bits
    step(1, 32'h0000_4000, 0, 15'h7ABC, 32'hFFFF_8010, 32'h0002_0000, 32'h0, "R5");
    // R5: immediate selected, register ignored
    step(1, 32'h0000_4000, 1, 15'd16, 32'h1234_5678, 32'h0002_0000, 32'h0, "R5");
    // R8: largest stride, row and column
    step(1, 32'h0000_0000, 1, 15'h7FFF, 32'h0, 32'h7FFF_0000, 32'h7FFF_FFFF, "R8");
    // R7: base near the top wraps
    step(1, 32'hFFFF_FFF0, 0, 15'd0, 32'd2, 32'h0001_0000, 32'h0008_0000, "R7");
    // R9: idle slots with junk operands keep the last result
    step(0, 32'hAAAA_AAAA, 1, 15'h5555, 32'hFFFF_FFFF, 32'h1234_5678, 32'h9ABC_DEF0, "R9");
    step(0, 32'h5555_5555, 0, 15'h2AAA, 32'h0F0F_0F0F, 32'h8765_4321, 32'h0FED_CBA9, "R9");
    step(0, 32'h0, 0, 15'h0, 32'h0, 32'h0, 32'h0, "R9");
    step(0, 32'h0, 0, 15'h0, 32'h0, 32'h0, 32'h0, "R9");

    // R10/R2: unbroken burst, all fields changing every cycle
    for (int i = 0; i < 24; i++) begin
      logic [31:0] r;
      r = (32'(i) * 32'h0137_9A31) ^ ((i % 2 == 1) ? 32'h8000_0000 : 32'h0);
      step(1, 32'h4000_0000 + 32'(i) * 32'h111, bit'(i % 2),
           15'(i * 1237 + 5), 32'hDEAD_0000 | 32'(i * 911),
           r, 32'(i) * 32'h00A3_5C17, "R10");
    end
    step(0, '0, 0, '0, '0, '0, '0, "R2");
    step(0, '0, 0, '0, '0, '0, '0, "R2");
    step(0, '0, 0, '0, '0, '0, '0, "R9");

    finish_run();
  end

endmodule